// File: doc/BRIEF.md
# Dual Interval Timer Register Block

This block is a byte-wide peripheral register file with sixteen locations picked by a 4-bit address. It contains two 16-bit down-counters, an auxiliary control byte, an interrupt flag byte and an interrupt enable byte. It drives one level-sensitive interrupt line. A CPU reaches it through a plain synchronous port: one write strobe and one read strobe, both sampled on the rising clock edge. Read data is combinational from the current state. Side effects of a read, such as clearing a flag, take hold at the edge that ends the read cycle.

Each timer takes one count step on every clock cycle in which `tickEn` is high. Timer 1 runs as a one-shot or as a free-running interval timer that reloads from its latch. Timer 2 is always a one-shot that keeps counting down after it expires. A pulse on `shiftDone` raises a third interrupt source. The parallel-port locations and the shift-register location are plain storage bytes only.

Top module: `twin_timer`

## Requirements
- R1: After reset the following values hold. Both timer latches are 0xFFFF. The Timer 1 counter is 0xFFFF. The Timer 2 counter is 0. The byte at address 2 is 0xFF. Every other stored byte, the flags and the enables are 0. Reading address 14 returns 0x80 and `irq` is low.
- R2: The enable register is at address 14. A write with bit 7 = 1 sets the enables that are 1 in bits 6:0. A write with bit 7 = 0 clears the enables that are 1 in bits 6:0. All other enables keep their value. A read returns the enables with bit 7 forced to 1.
- R3: Flag positions in the flag register (address 13) are:
  - bit 2: shift event,
  - bit 5: Timer 2,
  - bit 6: Timer 1.

  A read of address 13 returns the flags, with bit 7 set when any flag is pending together with its enable. `irq` is high exactly when a flag in bit 2, 5 or 6 is set together with its enable.
- R4: Writing address 13 clears every flag whose bit is 1 in the written byte and leaves the others unchanged.
- R5: Timer 1 uses three write addresses:
  - Address 4 or 6 writes the Timer 1 latch low byte.
  - Address 5 writes the latch high byte, loads the full latch into the counter, clears the Timer 1 flag and arms the one-shot.
  - Address 7 writes the latch high byte and clears the Timer 1 flag without touching the counter.

  Reads return:
  - address 4: counter low byte,
  - address 5: counter high byte,
  - addresses 6 and 7: latch low and high bytes.
- R6: Timer 1 steps from the loaded value down through 0 to 0xFFFF. It sets its flag on the step from 0 to 0xFFFF, which is L+1 steps after loading a value L. When control byte (address 11) bits 7:6 are not 01, the flag is set only once per load through address 5, and the counter keeps decrementing.
- R7: When address 11 bits 7:6 equal 01, Timer 1 reloads its latch on the step after 0xFFFF. This gives a flag every latch+2 steps.
- R8: Address 8 writes the Timer 2 latch low byte. A write of byte H to address 9 loads the counter with {H, latch low}, clears the Timer 2 flag and arms the timer. Timer 2 sets its flag on the step that takes the counter from 1 to 0. It then keeps decrementing without reload and sets no further flag until it is loaded again. Reads of addresses 8 and 9 return the counter low and high bytes.
- R9: The following reads clear a flag:
  - address 4 clears the Timer 1 flag,
  - address 8 clears the Timer 2 flag,
  - address 10 clears the shift flag.

  A one-cycle pulse on `shiftDone` sets the shift flag.
- R10: Some events can coincide with an access in one cycle.
  - A flag set event and a clear of the same flag by read or by a write to address 13: the flag ends up set.
  - A load through address 5 or 9 and a count step: the counter takes the loaded value and does not step.
- R11: Addresses 0, 1, 2, 3, 10, 11, 12 and 15 are plain bytes that read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe (enables read side effects) |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| tickEn | input | 1 | One count step for both timers when high |
| shiftDone | input | 1 | Pulse that sets the shift flag |
| irq | output | 1 | Level interrupt request |

## Verification
Flag setting by a timer expiry or `shiftDone`, and flag clearing by a read or a write to address 13, can land in the same clock cycle. Counter loading and a count step can also coincide. The bench provokes these cases by steering a Timer 1 counter to zero and then issuing a counter-low read during the step that wraps it. It also pulses `shiftDone` during a flag-clearing write, and writes a counter-high address while `tickEn` is high. The outcome is judged at the ports: the flag byte must still show the flag, and the counter must read back exactly the loaded value.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = 2 * DATA_W;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int FLAG_W   = DATA_W - 1;

  localparam int FLAG_SR = 2;
  localparam int FLAG_T2 = 5;
  localparam int FLAG_T1 = 6;
  localparam logic [FLAG_W-1:0] IRQ_MASK =
    FLAG_W'((1 << FLAG_SR) | (1 << FLAG_T2) | (1 << FLAG_T1));

  localparam logic [ADDR_W-1:0] A_DDR_B  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_T1_CLO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_T1_CHI = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_T1_LLO = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_T1_LHI = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_T2_CLO = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_T2_CHI = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_SHIFT  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(14);

  typedef struct packed {
    logic              t1LatLoWr;
    logic              t1LatHiWr;
    logic              t1Load;
    logic              t2LatLoWr;
    logic              t2Load;
    logic              ierWr;
    logic [FLAG_W-1:0] flagClr;
    logic [DATA_W-1:0] data;
  } strobe_t;

  typedef struct packed {
    logic [CNT_W-1:0]  t1Cnt;
    logic [CNT_W-1:0]  t1Lat;
    logic [CNT_W-1:0]  t2Cnt;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] ier;
  } view_t;

  function automatic logic isPlainReg(input int a);
    return (a <= 3) || (a == 10) || (a == 11) || (a == 12) || (a == 15);
  endfunction
endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  view_t             view,
  output strobe_t           strobe,
  output logic              freeRun,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] plainQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (isPlainReg(i)) begin : g_store
      always_ff @(posedge clk) begin
        if (!rstN)
          plainQ[i] <= (ADDR_W'(i) == A_DDR_B) ? '1 : '0;
        else if (wrEn && addr == ADDR_W'(i))
          plainQ[i] <= wrData;
      end
    end else begin : g_none
      assign plainQ[i] = '0;
    end
  end

  assign freeRun = (plainQ[A_CTRL][DATA_W-1 -: 2] == 2'b01);

  always_comb begin
    strobe           = '0;
    strobe.data      = wrData;
    strobe.t1LatLoWr = wrEn && (addr == A_T1_CLO || addr == A_T1_LLO);
    strobe.t1LatHiWr = wrEn && (addr == A_T1_LHI);
    strobe.t1Load    = wrEn && (addr == A_T1_CHI);
    strobe.t2LatLoWr = wrEn && (addr == A_T2_CLO);
    strobe.t2Load    = wrEn && (addr == A_T2_CHI);
    strobe.ierWr     = wrEn && (addr == A_ENABLE);
    if (wrEn && addr == A_FLAGS) strobe.flagClr = wrData[FLAG_W-1:0];
    if (rdEn && addr == A_T1_CLO) strobe.flagClr[FLAG_T1] = 1'b1;
    if (rdEn && addr == A_T2_CLO) strobe.flagClr[FLAG_T2] = 1'b1;
    if (rdEn && addr == A_SHIFT)  strobe.flagClr[FLAG_SR] = 1'b1;
  end

  always_comb begin
    case (addr)
      A_T1_CLO: rdData = view.t1Cnt[DATA_W-1:0];
      A_T1_CHI: rdData = view.t1Cnt[CNT_W-1:DATA_W];
      A_T1_LLO: rdData = view.t1Lat[DATA_W-1:0];
      A_T1_LHI: rdData = view.t1Lat[CNT_W-1:DATA_W];
      A_T2_CLO: rdData = view.t2Cnt[DATA_W-1:0];
      A_T2_CHI: rdData = view.t2Cnt[CNT_W-1:DATA_W];
      A_FLAGS:  rdData = {|(view.flags & view.ier), view.flags};
      A_ENABLE: rdData = {1'b1, view.ier};
      default:  rdData = plainQ[addr];
    endcase
  end

  // R11: a plain byte reads back what was just written to it
  p_plain_store_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_DDR_B) |=> (plainQ[A_DDR_B] == $past(wrData)));
endmodule

// File: rtl/twin_timer_datapath.sv
module twin_timer_datapath
  import twin_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  logic    shiftDone,
  input  logic    freeRun,
  input  strobe_t strobe,
  output view_t   view,
  output logic    irq
);
  logic [CNT_W-1:0]  t1Cnt, t1Lat, t2Cnt;
  logic [DATA_W-1:0] t2LatLo;
  logic              t1Armed, t1Wrap, t2Armed;
  logic [FLAG_W-1:0] flags, flagNext, ier;
  logic              t1Event, t2Event;

  assign t1Event = tickEn && !strobe.t1Load && (t1Cnt == '0) && (freeRun || t1Armed);
  assign t2Event = tickEn && !strobe.t2Load && (t2Cnt == CNT_W'(1)) && t2Armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1Lat <= '1; t1Cnt <= '1; t1Armed <= 1'b0; t1Wrap <= 1'b0;
    end else begin
      if (strobe.t1LatLoWr) t1Lat[DATA_W-1:0] <= strobe.data;
      if (strobe.t1LatHiWr || strobe.t1Load) t1Lat[CNT_W-1:DATA_W] <= strobe.data;
      if (strobe.t1Load) begin
        t1Cnt   <= {strobe.data, t1Lat[DATA_W-1:0]};
        t1Armed <= 1'b1;
        t1Wrap  <= 1'b0;
      end else if (tickEn) begin
        t1Wrap <= (t1Cnt == '0);
        if (t1Cnt == '0) begin
          t1Cnt   <= '1;
          t1Armed <= 1'b0;
        end else if (t1Wrap && freeRun) begin
          t1Cnt <= t1Lat;
        end else begin
          t1Cnt <= t1Cnt - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t2LatLo <= '1; t2Cnt <= '0; t2Armed <= 1'b0;
    end else begin
      if (strobe.t2LatLoWr) t2LatLo <= strobe.data;
      if (strobe.t2Load) begin
        t2Cnt   <= {strobe.data, t2LatLo};
        t2Armed <= 1'b1;
      end else if (tickEn) begin
        t2Cnt <= t2Cnt - CNT_W'(1);
        if (t2Cnt == CNT_W'(1)) t2Armed <= 1'b0;
      end
    end
  end

  always_comb begin
    flagNext = flags & ~strobe.flagClr;
    if (strobe.t1Load || strobe.t1LatHiWr) flagNext[FLAG_T1] = 1'b0;
    if (strobe.t2Load) flagNext[FLAG_T2] = 1'b0;
    if (t1Event)   flagNext[FLAG_T1] = 1'b1;
    if (t2Event)   flagNext[FLAG_T2] = 1'b1;
    if (shiftDone) flagNext[FLAG_SR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0; ier <= '0;
    end else begin
      flags <= flagNext;
      if (strobe.ierWr) begin
        if (strobe.data[DATA_W-1]) ier <= ier | strobe.data[FLAG_W-1:0];
        else                       ier <= ier & ~strobe.data[FLAG_W-1:0];
      end
    end
  end

  assign irq  = |(flags & ier & IRQ_MASK);
  assign view = '{t1Cnt: t1Cnt, t1Lat: t1Lat, t2Cnt: t2Cnt, flags: flags, ier: ier};

  // R5: a counter-high write loads {data, latch low} and drops the Timer 1 flag
  p_t1_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.t1Load |=> (t1Cnt == {$past(strobe.data), $past(t1Lat[DATA_W-1:0])}) && !flags[FLAG_T1]);
  // R6: the 0 -> 0xFFFF step in free-run mode raises the Timer 1 flag
  p_t1_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobe.t1Load && t1Cnt == '0 && freeRun) |=> flags[FLAG_T1]);
  // R7: the step after the wrap reloads the latch in free-run mode
  p_t1_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobe.t1Load && t1Wrap && freeRun) |=> (t1Cnt == $past(t1Lat)));
  // R8: Timer 2 never reloads on a step
  p_t2_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobe.t2Load) |=> (t2Cnt == $past(t2Cnt) - CNT_W'(1)));
  // R2: a set-style enable write leaves every requested bit on
  p_ier_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ierWr && strobe.data[DATA_W-1]) |=>
      ((ier & $past(strobe.data[FLAG_W-1:0])) == $past(strobe.data[FLAG_W-1:0])));
  // R4: a clear without a competing step removes the Timer 1 flag
  p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flagClr[FLAG_T1] && !tickEn) |=> !flags[FLAG_T1]);
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickEn,
  input  logic              shiftDone,
  output logic              irq
);
  strobe_t strobe;
  view_t   view;
  logic    freeRun;

  twin_timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .view(view), .strobe(strobe), .freeRun(freeRun),
    .rdData(rdData)
  );

  twin_timer_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .shiftDone(shiftDone),
    .freeRun(freeRun), .strobe(strobe), .view(view), .irq(irq)
  );
endmodule

// File: tb/twin_timer_tb_top.sv
`timescale 1ns/1ps
module twin_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, tickEn = 1'b0, shiftDone = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twin_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickEn(tickEn),
    .shiftDone(shiftDone), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a,
                       input logic [7:0] mask, input logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk); rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
    chk(req, v & mask, exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk("R1 ddr", 4'd2, 8'hFF, 8'hFF);
    rdChk("R1 portB", 4'd0, 8'hFF, 8'h00);
    rdChk("R1 ctrl", 4'd11, 8'hFF, 8'h00);
    rdChk("R1 t1 latch lo", 4'd6, 8'hFF, 8'hFF);
    rdChk("R1 t1 latch hi", 4'd7, 8'hFF, 8'hFF);
    rdChk("R1 t1 cnt hi", 4'd5, 8'hFF, 8'hFF);
    rdChk("R1 t1 cnt lo", 4'd4, 8'hFF, 8'hFF);
    rdChk("R1 t2 cnt lo", 4'd8, 8'hFF, 8'h00);
    rdChk("R1 t2 cnt hi", 4'd9, 8'hFF, 8'h00);
    rdChk("R1 flags", 4'd13, 8'hFF, 8'h00);
    rdChk("R1 enable", 4'd14, 8'hFF, 8'h80);
    chk("R1 irq", irq, 0);

    // R11 plain storage
    foreach (dut_i.rdData[i]) begin end
    for (int a = 0; a < 16; a++) begin
      if (a <= 3 || a == 10 || a == 12 || a == 15) begin
        wr(4'(a), 8'h5A ^ 8'(a * 17));
        rdChk("R11 plain byte", 4'(a), 8'hFF, 8'h5A ^ 8'(a * 17));
      end
    end

    // R2 enable set/clear convention
    wr(4'd14, 8'hE4);
    rdChk("R2 set", 4'd14, 8'hFF, 8'hE4);
    wr(4'd14, 8'h04);
    rdChk("R2 clear", 4'd14, 8'hFF, 8'hE0);
    wr(4'd14, 8'h84);
    rdChk("R2 set again", 4'd14, 8'hFF, 8'hE4);
    wr(4'd14, 8'h00);
    rdChk("R2 clear none", 4'd14, 8'hFF, 8'hE4);

    // R6 one-shot sweep (control byte 0)
    foreach (dut_i.rdData[i]) begin end
    for (int k = 0; k < 6; k++) begin
      int lv;
      lv = (k == 4) ? 7 : (k == 5) ? 300 : k;
      wr(4'd6, 8'(lv));
      wr(4'd5, 8'(lv >> 8));
      rdChk("R5 load hi", 4'd5, 8'hFF, 8'(lv >> 8));
      ticks(lv);
      rdChk("R6 no flag early", 4'd13, 8'h40, 8'h00);
      rdChk("R6 cnt zero", 4'd5, 8'hFF, 8'h00);
      ticks(1);
      rdChk("R6 flag + R3 summary", 4'd13, 8'hFF, 8'hC0);
      chk("R3 irq high", irq, 1);
      rdChk("R6 cnt after wrap", 4'd5, 8'hFF, 8'hFF);
      wr(4'd13, 8'h40);
      rdChk("R4 flag cleared", 4'd13, 8'hFF, 8'h00);
      chk("R3 irq low", irq, 0);
      ticks(lv + 2);
      rdChk("R6 no refire", 4'd13, 8'h40, 8'h00);
    end

    // R7 free-run sweep
    wr(4'd11, 8'h40);
    for (int k = 0; k < 3; k++) begin
      int lv;
      lv = (k == 2) ? 4 : k;
      wr(4'd6, 8'(lv));
      wr(4'd5, 8'h00);
      ticks(lv + 1);
      rdChk("R7 first flag", 4'd13, 8'h40, 8'h40);
      rdChk("R7 at minus one hi", 4'd5, 8'hFF, 8'hFF);
      rdChk("R9 rd cnt lo value", 4'd4, 8'hFF, 8'hFF);
      rdChk("R9 rd lo clears t1", 4'd13, 8'h40, 8'h00);
      ticks(1);
      rdChk("R7 reloaded", 4'd4, 8'hFF, 8'(lv));
      for (int p = 0; p < 2; p++) begin
        ticks(lv);
        rdChk("R7 no flag mid period", 4'd13, 8'h40, 8'h00);
        ticks(1);
        rdChk("R7 period flag", 4'd13, 8'h40, 8'h40);
        wr(4'd13, 8'h40);
        ticks(1);
      end
    end
    wr(4'd11, 8'h00);

    // R5 latch-high write without reload
    wr(4'd6, 8'h10);
    wr(4'd5, 8'h00);
    ticks(3);
    wr(4'd7, 8'h22);
    rdChk("R5 no reload hi", 4'd5, 8'hFF, 8'h00);
    rdChk("R5 no reload lo", 4'd4, 8'hFF, 8'h0D);
    rdChk("R5 latch hi", 4'd7, 8'hFF, 8'h22);
    ticks(14);
    rdChk("R5 flag before latch-hi", 4'd13, 8'h40, 8'h40);
    wr(4'd7, 8'h33);
    rdChk("R5 latch-hi clears flag", 4'd13, 8'h40, 8'h00);
    rdChk("R5 latch hi new", 4'd7, 8'hFF, 8'h33);

    // R8 Timer 2 sweep
    for (int k = 0; k < 4; k++) begin
      int v;
      v = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 256;
      wr(4'd8, 8'(v));
      wr(4'd9, 8'(v >> 8));
      rdChk("R8 load lo", 4'd8, 8'hFF, 8'(v));
      rdChk("R8 load hi", 4'd9, 8'hFF, 8'(v >> 8));
      ticks(v - 1);
      rdChk("R8 no flag early", 4'd13, 8'h20, 8'h00);
      ticks(1);
      rdChk("R8 flag at zero", 4'd13, 8'h20, 8'h20);
      rdChk("R9 t2 lo reads zero", 4'd8, 8'hFF, 8'h00);
      rdChk("R9 rd t2 lo clears", 4'd13, 8'h20, 8'h00);
      ticks(3);
      rdChk("R8 no reload hi", 4'd9, 8'hFF, 8'hFF);
      rdChk("R8 no reload lo", 4'd8, 8'hFF, 8'hFD);
    end

    // R6 / R8 one flag per load across a full wrap
    wr(4'd6, 8'h05); wr(4'd5, 8'h00);
    wr(4'd8, 8'h03); wr(4'd9, 8'h00);
    ticks(6);
    rdChk("R6 R8 both fired", 4'd13, 8'h60, 8'h60);
    wr(4'd13, 8'h60);
    ticks(66000);
    rdChk("R6 R8 once only", 4'd13, 8'h60, 8'h00);

    // R9 shift flag
    @(negedge clk); shiftDone = 1'b1;
    @(negedge clk); shiftDone = 1'b0;
    rdChk("R9 shift sets", 4'd13, 8'hFF, 8'h84);
    chk("R3 irq shift", irq, 1);
    rdChk("R11 shift byte", 4'd10, 8'h00, 8'h00);
    rdChk("R9 shift read clears", 4'd13, 8'h04, 8'h00);
    chk("R3 irq shift low", irq, 0);

    // R10 coincidences
    wr(4'd6, 8'h02); wr(4'd5, 8'h00);
    ticks(2);
    @(negedge clk); tickEn = 1'b1; rdEn = 1'b1; addr = 4'd4;
    @(negedge clk); tickEn = 1'b0; rdEn = 1'b0;
    rdChk("R10 set beats read clear", 4'd13, 8'h40, 8'h40);
    wr(4'd13, 8'h40);
    @(negedge clk); shiftDone = 1'b1; wrEn = 1'b1; addr = 4'd13; wrData = 8'h04;
    @(negedge clk); shiftDone = 1'b0; wrEn = 1'b0;
    rdChk("R10 set beats write clear", 4'd13, 8'h04, 8'h04);
    wr(4'd13, 8'h04);
    rdChk("R4 shift cleared", 4'd13, 8'h04, 8'h00);
    wr(4'd6, 8'h09);
    @(negedge clk); tickEn = 1'b1; wrEn = 1'b1; addr = 4'd5; wrData = 8'h00;
    @(negedge clk); tickEn = 1'b0; wrEn = 1'b0;
    rdChk("R10 t1 load beats tick lo", 4'd4, 8'hFF, 8'h09);
    rdChk("R10 t1 load beats tick hi", 4'd5, 8'hFF, 8'h00);
    wr(4'd8, 8'h07);
    @(negedge clk); tickEn = 1'b1; wrEn = 1'b1; addr = 4'd9; wrData = 8'h00;
    @(negedge clk); tickEn = 1'b0; wrEn = 1'b0;
    rdChk("R10 t2 load beats tick", 4'd8, 8'hFF, 8'h07);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule